// File: doc/BRIEF.md
# Floating-Point Invalid-Operation Screen

This block screens the operands of one extended-precision arithmetic operation (add, subtract, multiply, divide or square root) before the regular arithmetic datapath commits a result. It classifies each operand and decides whether the operation is invalid or touches a denormal. It then chooses one of three outcomes. It can write a special result of its own (a default NaN, a quieted NaN or a signed zero). It can hand the write to the regular datapath. Or it can raise an exception request and block every write, so that the destination and the stack pointer stay as they were.

Each operand is a sign bit, a biased exponent field and a significand with an explicit integer bit. Two mask inputs decide whether each exception is handled in place (masked) or reported to software (unmasked). The verdict is registered and appears one clock after the operation is presented.

Top module: `fpinv_unit`

## Requirements
- R1: An operand with a nonzero exponent and an integer bit of 0 (unnormal, pseudo-NaN, pseudo-infinity) raises invalid. The special result is the default NaN: sign 1, all-ones exponent, significand 0xC000_0000_0000_0000. Operand layout: sign is bit 79, exponent is bits 78:64, significand is bits 63:0, and bit 63 is the integer bit.
- R2: A signalling NaN operand (all-ones exponent, integer bit 1, bit 62 clear, bits 61:0 nonzero) raises invalid. The result is that NaN with bit 62 set and its sign and payload kept.
- R3: A quiet NaN operand (bit 62 set) raises no invalid and is written as the result. When both operands are NaNs, both are quieted and the one with the larger significand is written, with the first operand winning a tie. An unsupported operand takes precedence over a NaN.
- R4: Adding infinities of opposite sign, or subtracting infinities of the same sign, raises invalid with the default NaN.
- R5: Infinity times zero in either order, infinity divided by infinity, and zero divided by zero each raise invalid with the default NaN.
- R6: Square root of a negative nonzero operand (including negative infinity and negative denormals) raises invalid with the default NaN. Square root of negative zero writes negative zero with no flag. Square root ignores the second operand.
- R7: When invalid is not raised, a denormal operand (exponent 0, significand nonzero) raises the denormal flag. Invalid and denormal are never raised together.
- R8: Invalid with mask_inv low, or denormal with mask_den low, asserts exc_req, and neither special_wr nor use_datapath is asserted.
- R9: Opcodes are ADD=0, SUB=1, MUL=2, DIV=3, SQRT=4. Codes 5 to 7 raise no flag and select the datapath.
- R10: The verdict appears on the outputs one clock after in_valid. While out_valid is low, and during reset, every output is 0.
- R11: With out_valid high, exactly one of exc_req, special_wr and use_datapath is high. special_result is 0 unless special_wr is high. Ordinary operands select the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation code |
| opa | input | 80 | First (or only) operand |
| opb | input | 80 | Second operand |
| mask_inv | input | 1 | Invalid exception is masked |
| mask_den | input | 1 | Denormal exception is masked |
| out_valid | output | 1 | Verdict valid |
| inv_flag | output | 1 | Invalid-operation detected |
| den_flag | output | 1 | Denormal operand detected |
| exc_req | output | 1 | Unmasked exception, no write allowed |
| special_wr | output | 1 | Write special_result to the destination |
| use_datapath | output | 1 | Write the regular datapath result |
| special_result | output | 80 | Special value to write |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent, a 64-bit significand and the registered output stage. With these values the bench can drive the exact 80-bit encodings, such as pseudo-infinities, unnormals, pseudo-denormals and NaN payloads that differ only in their low bits. These encodings exercise the precedence order and the larger-significand choice. The one-cycle latency and the assertions guarding the registered verdict are also exercised by this configuration.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;
   localparam logic [2:0] OP_ADD  = 3'd0;
   localparam logic [2:0] OP_SUB  = 3'd1;
   localparam logic [2:0] OP_MUL  = 3'd2;
   localparam logic [2:0] OP_DIV  = 3'd3;
   localparam logic [2:0] OP_SQRT = 3'd4;

   typedef struct packed {
      logic sign;
      logic zero;
      logic den;
      logic inf;
      logic qnan;
      logic snan;
      logic unsup;
   } fp_class_t;
endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
   import fpinv_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] val_i,
   output fp_class_t    cls_o
);
   logic [EXP_W-1:0] expo;
   logic             int_bit;
   logic             q_bit;
   logic [MAN_W-3:0] low_bits;
   logic             e_ones, e_zero;

   always_comb begin
      expo     = val_i[W-2:MAN_W];
      int_bit  = val_i[MAN_W-1];
      q_bit    = val_i[MAN_W-2];
      low_bits = val_i[MAN_W-3:0];
      e_ones   = &expo;
      e_zero   = ~|expo;
      cls_o.sign  = val_i[W-1];
      cls_o.zero  = e_zero & ~int_bit & ~q_bit & ~|low_bits;
      cls_o.den   = e_zero & (int_bit | q_bit | |low_bits);
      cls_o.inf   = e_ones & int_bit & ~q_bit & ~|low_bits;
      cls_o.qnan  = e_ones & int_bit & q_bit;
      cls_o.snan  = e_ones & int_bit & ~q_bit & |low_bits;
      cls_o.unsup = ~e_zero & ~int_bit;
   end
endmodule

// File: rtl/fpinv_nanpick.sv
module fpinv_nanpick #(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         a_nan_i,
   input  logic         b_nan_i,
   output logic [W-1:0] nan_o
);
   localparam logic [W-1:0] QUIET_BIT = W'(1) << (MAN_W - 2);
   logic [W-1:0] qa, qb;

   always_comb begin
      qa = a_i | QUIET_BIT;
      qb = b_i | QUIET_BIT;
      if (a_nan_i && b_nan_i)
         nan_o = (qb[MAN_W-1:0] > qa[MAN_W-1:0]) ? qb : qa;
      else if (b_nan_i)
         nan_o = qb;
      else
         nan_o = qa;
   end
endmodule

// File: rtl/fpinv_decide.sv
module fpinv_decide
   import fpinv_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int MAN_W = 64,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic [2:0]   op_i,
   input  fp_class_t    ca_i,
   input  fp_class_t    cb_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] nan_i,
   output logic         inv_o,
   output logic         den_o,
   output logic         special_o,
   output logic [W-1:0] res_o
);
   localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};
   logic arith, bad_inf;

   always_comb begin
      arith   = (op_i <= OP_SQRT);
      bad_inf = ((op_i == OP_ADD) && ca_i.inf && cb_i.inf && (ca_i.sign != cb_i.sign)) ||
                ((op_i == OP_SUB) && ca_i.inf && cb_i.inf && (ca_i.sign == cb_i.sign)) ||
                ((op_i == OP_MUL) && ((ca_i.inf && cb_i.zero) || (ca_i.zero && cb_i.inf))) ||
                ((op_i == OP_DIV) && ((ca_i.inf && cb_i.inf) || (ca_i.zero && cb_i.zero)));
      inv_o     = 1'b0;
      special_o = 1'b0;
      res_o     = '0;
      if (arith) begin
         if (ca_i.unsup || cb_i.unsup) begin
            inv_o = 1'b1; special_o = 1'b1; res_o = INDEF;
         end else if (ca_i.snan || ca_i.qnan || cb_i.snan || cb_i.qnan) begin
            inv_o = ca_i.snan | cb_i.snan; special_o = 1'b1; res_o = nan_i;
         end else if ((op_i == OP_SQRT) && ca_i.sign && ca_i.zero) begin
            special_o = 1'b1; res_o = a_i;
         end else if (((op_i == OP_SQRT) && ca_i.sign) || bad_inf) begin
            inv_o = 1'b1; special_o = 1'b1; res_o = INDEF;
         end
      end
      den_o = arith & ~inv_o & (ca_i.den | cb_i.den);
   end
endmodule

// File: rtl/fpinv_unit.sv
module fpinv_unit
   import fpinv_pkg::*;
#(
   parameter int EXP_W      = 15,
   parameter int MAN_W      = 64,
   parameter bit OUTPUT_REG = 1'b1,
   localparam int W = 1 + EXP_W + MAN_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [2:0]   op_code,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   input  logic         mask_inv,
   input  logic         mask_den,
   output logic         out_valid,
   output logic         inv_flag,
   output logic         den_flag,
   output logic         exc_req,
   output logic         special_wr,
   output logic         use_datapath,
   output logic [W-1:0] special_result
);
   if (EXP_W < 2)  begin : g_chk_exp $error("EXP_W must be at least 2"); end
   if (MAN_W < 3)  begin : g_chk_man $error("MAN_W must be at least 3"); end

   logic [W-1:0] opnd [2];
   fp_class_t    cls  [2];
   fp_class_t    cb_eff;
   logic         binary_op;
   logic [W-1:0] nan_res, res_c;
   logic         inv_c, den_c, spec_c, exc_c, wr_c, dp_c;

   assign opnd[0] = opa;
   assign opnd[1] = opb;

   for (genvar i = 0; i < 2; i++) begin : g_cls
      fpinv_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .val_i(opnd[i]), .cls_o(cls[i]));
   end

   assign binary_op = (op_code < OP_SQRT);
   assign cb_eff    = binary_op ? cls[1] : '0;

   fpinv_nanpick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
      .a_i(opa), .b_i(opb),
      .a_nan_i(cls[0].snan | cls[0].qnan),
      .b_nan_i(cb_eff.snan | cb_eff.qnan),
      .nan_o(nan_res));

   fpinv_decide #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dec (
      .op_i(op_code), .ca_i(cls[0]), .cb_i(cb_eff), .a_i(opa), .nan_i(nan_res),
      .inv_o(inv_c), .den_o(den_c), .special_o(spec_c), .res_o(res_c));

   always_comb begin
      exc_c = (inv_c & ~mask_inv) | (den_c & ~mask_den);
      wr_c  = spec_c & ~exc_c;
      dp_c  = ~spec_c & ~exc_c;
   end

   if (OUTPUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid      <= 1'b0;
            inv_flag       <= 1'b0;
            den_flag       <= 1'b0;
            exc_req        <= 1'b0;
            special_wr     <= 1'b0;
            use_datapath   <= 1'b0;
            special_result <= '0;
         end else begin
            out_valid      <= in_valid;
            inv_flag       <= in_valid & inv_c;
            den_flag       <= in_valid & den_c;
            exc_req        <= in_valid & exc_c;
            special_wr     <= in_valid & wr_c;
            use_datapath   <= in_valid & dp_c;
            special_result <= (in_valid & wr_c) ? res_c : '0;
         end
      end

      assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> !inv_flag && !den_flag && !exc_req && !special_wr &&
                        !use_datapath && special_result == '0);
      assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> $countones({exc_req, special_wr, use_datapath}) == 1);
      assert_unmasked_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && inv_flag && !$past(mask_inv) |-> exc_req && !special_wr);
      assert_invalid_is_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && special_wr && inv_flag |->
            (&special_result[W-2:MAN_W]) && special_result[MAN_W-1:MAN_W-2] == 2'b11);
      assert_sqrt_negzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && $past(op_code) == OP_SQRT && $past(opa) == {1'b1, {(W-1){1'b0}}}
            |-> !inv_flag && !den_flag && special_wr && special_result == {1'b1, {(W-1){1'b0}}});
      assert_undef_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && $past(op_code) > OP_SQRT |-> use_datapath && !inv_flag && !den_flag);
      assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !(inv_flag && den_flag));
   end else begin : g_comb
      always_comb begin
         out_valid      = in_valid;
         inv_flag       = in_valid & inv_c;
         den_flag       = in_valid & den_c;
         exc_req        = in_valid & exc_c;
         special_wr     = in_valid & wr_c;
         use_datapath   = in_valid & dp_c;
         special_result = (in_valid & wr_c) ? res_c : '0;
      end
   end
endmodule

// File: tb/fpinv_unit_test.sv
module fpinv_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [79:0] opa = '0, opb = '0;
   logic        mask_inv = 1'b1, mask_den = 1'b1;
   logic        out_valid, inv_flag, den_flag, exc_req, special_wr, use_datapath;
   logic [79:0] special_result;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   fpinv_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .opa(opa), .opb(opb), .mask_inv(mask_inv), .mask_den(mask_den),
      .out_valid(out_valid), .inv_flag(inv_flag), .den_flag(den_flag),
      .exc_req(exc_req), .special_wr(special_wr), .use_datapath(use_datapath),
      .special_result(special_result));

   localparam logic [79:0] ONE    = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] MTWO   = {1'b1, 15'h4000, 64'hA000_0000_0000_0000};
   localparam logic [79:0] PINF   = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] NINF   = {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000};
   localparam logic [79:0] PZERO  = 80'h0;
   localparam logic [79:0] NZERO  = {1'b1, 79'h0};
   localparam logic [79:0] DENRM  = {1'b0, 15'h0, 64'h0000_0000_0000_1234};
   localparam logic [79:0] PSDEN  = {1'b1, 15'h0, 64'h8000_0000_0000_0001};
   localparam logic [79:0] SNAN1  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0001};
   localparam logic [79:0] SNAN2  = {1'b1, 15'h7FFF, 64'h8000_0000_00FF_0000};
   localparam logic [79:0] QNAN1  = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0007};
   localparam logic [79:0] UNNRM  = {1'b0, 15'h3FFF, 64'h4000_0000_0000_0000};
   localparam logic [79:0] PSINF  = {1'b0, 15'h7FFF, 64'h0000_0000_0000_0000};
   localparam logic [79:0] INDEF  = {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000};

   // kinds: 0 finite, 1 zero, 2 denormal, 3 infinity, 4 quiet NaN, 5 signalling NaN, 6 unsupported
   function automatic int kind(input logic [79:0] x);
      logic [14:0] e = x[78:64];
      logic [63:0] m = x[63:0];
      if (e == 15'h0) return (m == 64'h0) ? 1 : 2;
      if (!m[63]) return 6;
      if (e != 15'h7FFF) return 0;
      if (m[62]) return 4;
      return (m[61:0] == 62'h0) ? 3 : 5;
   endfunction

   // returns {valid, inv, den, exc, wr, dp, result}
   function automatic logic [85:0] model(input logic [2:0] op, input logic [79:0] a, b,
                                         input logic mi, md);
      int ka, kb;
      logic inv = 0, den = 0, spec = 0, exc, wr, dp;
      logic [79:0] res = '0, qa, qb;
      if (op > 3'd4) return {1'b1, 4'b0000, 1'b1, 80'h0};
      ka = kind(a);
      kb = (op == 3'd4) ? 0 : kind(b);
      qa = a | (80'h1 << 62);
      qb = b | (80'h1 << 62);
      if (ka == 6 || kb == 6) begin inv = 1; spec = 1; res = INDEF; end
      else if (ka >= 4 || kb >= 4) begin
         inv = (ka == 5 || kb == 5); spec = 1;
         if (ka >= 4 && kb >= 4) res = (qb[63:0] > qa[63:0]) ? qb : qa;
         else res = (ka >= 4) ? qa : qb;
      end else if (op == 3'd4 && a[79]) begin
         spec = 1;
         if (ka == 1) res = a; else begin inv = 1; res = INDEF; end
      end else if ((op == 3'd0 && ka == 3 && kb == 3 && a[79] != b[79]) ||
                   (op == 3'd1 && ka == 3 && kb == 3 && a[79] == b[79]) ||
                   (op == 3'd2 && ((ka == 3 && kb == 1) || (ka == 1 && kb == 3))) ||
                   (op == 3'd3 && ((ka == 3 && kb == 3) || (ka == 1 && kb == 1)))) begin
         inv = 1; spec = 1; res = INDEF;
      end
      den = !inv && (ka == 2 || kb == 2);
      exc = (inv && !mi) || (den && !md);
      wr  = spec && !exc;
      dp  = !spec && !exc;
      return {1'b1, inv, den, exc, wr, dp, wr ? res : 80'h0};
   endfunction

   task automatic compare(input logic [85:0] exp, input string tag);
      logic [85:0] act = {out_valid, inv_flag, den_flag, exc_req, special_wr, use_datapath,
                          special_result};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [2:0] op, input logic [79:0] a, b,
                        input logic mi, md, input string tag);
      logic [85:0] exp;
      in_valid = 1'b1; op_code = op; opa = a; opb = b; mask_inv = mi; mask_den = md;
      exp = model(op, a, b, mi, md);
      @(negedge clk);
      compare(exp, tag);
      in_valid = 1'b0;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      compare(86'h0, tag);
   endtask

   function automatic logic [79:0] pool(input int unsigned s);
      case (s % 14)
         0: return ONE;   1: return MTWO;  2: return PINF;  3: return NINF;
         4: return PZERO; 5: return NZERO; 6: return DENRM; 7: return PSDEN;
         8: return SNAN1; 9: return SNAN2; 10: return QNAN1; 11: return UNNRM;
         12: return PSINF; default: return INDEF;
      endcase
   endfunction

   initial begin
      #400000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(86'h0, "R10 reset state");
      rst_n = 1'b1;
      idle("R10 idle after reset");

      apply(3'd0, ONE, MTWO, 1, 1, "R11 ordinary add");
      idle("R10 single-cycle pulse");
      apply(3'd2, UNNRM, ONE, 1, 1, "R1 unnormal");
      apply(3'd0, ONE, PSINF, 1, 1, "R1 pseudo-infinity");
      apply(3'd1, UNNRM, QNAN1, 1, 1, "R3 unsupported beats NaN");
      apply(3'd0, SNAN1, ONE, 1, 1, "R2 signalling NaN quieted");
      apply(3'd3, ONE, SNAN2, 1, 1, "R2 signalling NaN in second operand");
      apply(3'd2, QNAN1, ONE, 1, 1, "R3 quiet NaN no invalid");
      apply(3'd0, SNAN1, QNAN1, 1, 1, "R3 larger significand picked");
      apply(3'd0, SNAN2, SNAN1, 1, 1, "R3 two signalling NaNs");
      apply(3'd0, QNAN1, QNAN1, 1, 1, "R3 tie keeps first");
      apply(3'd0, PINF, NINF, 1, 1, "R4 add opposite infinities");
      apply(3'd0, PINF, PINF, 1, 1, "R4 add like infinities valid");
      apply(3'd1, NINF, NINF, 1, 1, "R4 subtract like infinities");
      apply(3'd2, PZERO, NINF, 1, 1, "R5 zero times infinity");
      apply(3'd2, PINF, NZERO, 1, 1, "R5 infinity times zero");
      apply(3'd3, NINF, PINF, 1, 1, "R5 infinity over infinity");
      apply(3'd3, NZERO, PZERO, 1, 1, "R5 zero over zero");
      apply(3'd3, ONE, PZERO, 1, 1, "R5 finite over zero to datapath");
      apply(3'd4, MTWO, ONE, 1, 1, "R6 root of negative");
      apply(3'd4, NZERO, SNAN1, 1, 1, "R6 root of negative zero, second operand ignored");
      apply(3'd4, NINF, ONE, 1, 1, "R6 root of negative infinity");
      apply(3'd4, PSDEN, ONE, 1, 0, "R6 root of negative denormal");
      apply(3'd2, DENRM, ONE, 1, 1, "R7 masked denormal");
      apply(3'd2, DENRM, ONE, 1, 0, "R8 unmasked denormal");
      apply(3'd0, DENRM, QNAN1, 1, 1, "R7 denormal with quiet NaN");
      apply(3'd0, DENRM, SNAN1, 1, 0, "R7 invalid suppresses denormal");
      apply(3'd0, PINF, NINF, 0, 1, "R8 unmasked invalid");
      apply(3'd0, SNAN1, ONE, 0, 1, "R8 unmasked signalling NaN");
      apply(3'd5, SNAN1, UNNRM, 0, 0, "R9 code 5");
      apply(3'd7, DENRM, PINF, 0, 0, "R9 code 7");
      idle("R10 idle");

      for (int i = 0; i < 600; i++) begin
         apply(3'($urandom_range(0, 7)), pool($urandom), pool($urandom),
               1'($urandom), 1'($urandom), "R11 mixed operands");
      end
      idle("R10 final idle");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule